// File: doc/BRIEF.md
# Region-Dependent Bus Cycle Sequencer

This block sits between a processor core and the three kinds of target a small controller sees: fast on-chip memory, a 128-byte field of on-chip peripheral registers at the top of the first 64 KB, and the external bus. It divides the oscillator clock by two to form the system clock. One system clock period is one state.

For each request, the block decodes the address. It then runs a bus cycle whose length and data width suit the selected region. On-chip memory takes two states over a 16-bit path. The register field and external space each take three states over an 8-bit path. A word access to an 8-bit region is split into two byte cycles, high byte first. The external control strobes stay quiet during every on-chip cycle.

In maximum mode a page register supplies four upper address bits, giving 1 MB of physical space. Offsets never carry into the page, so a word that straddles offset 0xFFFF wraps back to offset 0x0000 of the same page. In minimum mode the page register is ignored. The core sees a ready/valid acceptance and a one-cycle done pulse that comes with the read data.

Top module: `bus_cycle_seq`

## Requirements
- R1: `sys_clk` toggles on every oscillator cycle, so one state lasts two oscillator cycles. `done` is only ever high while `sys_clk` is high, which is the second half of a state.
- R2: An on-chip memory access occupies exactly two states. Requests accepted at an edge see `done` in the 4th oscillator cycle after that edge. Words move over the 16-bit path; the byte at an even address is bits 15:8. A word access ignores address bit 0. A byte write enables only its own lane (`mem_be` bit 1 = bits 15:8).
- R3: With the effective page equal to 0, offsets 0xFF80 to 0xFFFF select the register field. A byte access there takes three states (done in cycle 6), `reg_addr` equals offset bits 6:0, and the external strobes stay idle. With the effective page equal to 0, offsets 0xFB80 to 0xFF7F select on-chip memory. Every other address is external.
- R4: While `mem_en` is high, `ext_as_n`, `ext_rd_n` and `ext_wr_n` are all high.
- R5: In maximum mode the external address is {page register, 16-bit offset}.
- R6: The second byte of a split word uses offset+1 modulo 2^16 in the same page. For example, offset 0xFFFF is followed by offset 0x0000.
- R7: In minimum mode the page register has no effect. The upper four address bits are 0, and region decoding treats the page as 0.
- R8: `done` is a one-cycle pulse on the final state. `req_ready` is high only in the second half of an idle state or together with `done`, so back-to-back accesses leave no gap.
- R9: An external byte cycle takes three states. `ext_as_n`, and either `ext_rd_n` (read) or `ext_wr_n` (write), are low only in states two and three, which is oscillator cycles 3 to 6 of that byte.
- R10: A page write applies from the next access not yet begun. An access accepted at the same edge as the page write still uses the old page.
- R11: A word access to the register field or to external space runs two byte cycles, high byte (data bits 15:8) first, and raises `done` only after the second (cycle 12).
- R12: `rdata` is valid while `done` is high. Byte reads are right-justified with bits 15:8 zero.
- R13: During reset `req_ready`, `done`, `mem_en`, `reg_en` and `rdata` are 0, and all external strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| max_mode | input | 1 | 1 = page register extends the address |
| page_we | input | 1 | Page register write strobe |
| page_din | input | 4 | Page register write value |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 16 | Logical address |
| req_write | input | 1 | 1 = write |
| req_word | input | 1 | 1 = 16-bit access |
| req_wdata | input | 16 | Write data |
| done | output | 1 | Final-state pulse |
| rdata | output | 16 | Read data |
| sys_clk | output | 1 | System clock (oscillator / 2) |
| mem_en | output | 1 | On-chip memory enable |
| mem_we | output | 1 | On-chip memory write |
| mem_addr | output | 15 | On-chip memory word address |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | On-chip memory write data |
| mem_rdata | input | 16 | On-chip memory read data (synchronous) |
| reg_en | output | 1 | Register field select |
| reg_we | output | 1 | Register field write |
| reg_addr | output | 7 | Register index |
| reg_wdata | output | 8 | Register write byte |
| reg_rdata | input | 8 | Register read byte |
| ext_addr | output | 20 | External physical address |
| ext_as_n | output | 1 | External address strobe, active low |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte |

## Verification
A wrong cycle counter or a wrong region latch shows within the same access. `done` arrives at cycle 4, 6 or 12 instead of the expected one, or the strobe-low count differs from 4 per external byte. A wrong offset or page register shows as a wrong `ext_addr` or `reg_addr` in the first or second byte of that access. A wrong lane select corrupts a word read back a few accesses later. The sweep runs every region, direction and width in both modes. Its addresses sit at the region edges and at the page-wrap offset.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_MEM  = 2'd1,
    RG_REG  = 2'd2,
    RG_EXT  = 2'd3
  } region_e;

  localparam logic [1:0] WIDE_STATES   = 2'd2;
  localparam logic [1:0] NARROW_STATES = 2'd3;
endpackage

// File: rtl/bcs_phase.sv
module bcs_phase (
  input  logic clk,
  input  logic rst,
  output logic phase,
  output logic state_end,
  output logic state_mid
);
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  assign state_end = phase;
  assign state_mid = ~phase;

  assert_phase_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    phase |=> !phase);
endmodule

// File: rtl/bcs_page_reg.sv
module bcs_page_reg #(
  parameter int PG_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PG_W-1:0] din,
  output logic [PG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/bcs_decode.sv
module bcs_decode import bcs_pkg::*; #(
  parameter int              LA_W   = 16,
  parameter int              PG_W   = 4,
  parameter logic [LA_W-1:0] MEM_LO = 16'hFB80,
  parameter logic [LA_W-1:0] MEM_HI = 16'hFF7F,
  parameter logic [LA_W-1:0] REG_LO = 16'hFF80
) (
  input  logic            max_mode,
  input  logic [PG_W-1:0] page,
  input  logic [LA_W-1:0] offset,
  output logic [PG_W-1:0] page_eff,
  output region_e         region
);
  always_comb begin
    page_eff = max_mode ? page : '0;
    if (page_eff != '0)
      region = RG_EXT;
    else if (offset >= REG_LO)
      region = RG_REG;
    else if (offset >= MEM_LO && offset <= MEM_HI)
      region = RG_MEM;
    else
      region = RG_EXT;
  end
endmodule

// File: rtl/bcs_rd_merge.sv
module bcs_rd_merge import bcs_pkg::*; #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  region_e           region,
  input  logic              word,
  input  logic              half,
  input  logic              lane_odd,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic [BYTE_W-1:0] ext_rdata,
  output logic [WORD_W-1:0] rdata
);
  logic [BYTE_W-1:0] narrow;
  logic [BYTE_W-1:0] lane;

  assign narrow = (region == RG_REG) ? reg_rdata : ext_rdata;
  assign lane   = lane_odd ? mem_rdata[BYTE_W-1:0] : mem_rdata[WORD_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (cap_en) begin
      if (region == RG_MEM) begin
        rdata <= word ? mem_rdata : {{BYTE_W{1'b0}}, lane};
      end else if (!word) begin
        rdata <= {{BYTE_W{1'b0}}, narrow};
      end else if (!half) begin
        rdata[WORD_W-1:BYTE_W] <= narrow;
      end else begin
        rdata[BYTE_W-1:0] <= narrow;
      end
    end
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq import bcs_pkg::*; #(
  parameter int              LA_W   = 16,
  parameter int              PG_W   = 4,
  parameter int              BYTE_W = 8,
  parameter int              REG_AW = 7,
  parameter logic [LA_W-1:0] MEM_LO = 16'hFB80,
  parameter logic [LA_W-1:0] MEM_HI = 16'hFF7F,
  parameter logic [LA_W-1:0] REG_LO = 16'hFF80,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int PA_W   = LA_W + PG_W,
  localparam int MA_W   = LA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              max_mode,
  input  logic              page_we,
  input  logic [PG_W-1:0]   page_din,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              sys_clk,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [1:0]        mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              reg_en,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [PA_W-1:0]   ext_addr,
  output logic              ext_as_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic [BYTE_W-1:0] ext_wdata,
  input  logic [BYTE_W-1:0] ext_rdata
);
  logic state_end, state_mid;
  logic [PG_W-1:0] page_q;
  logic [PG_W-1:0] dec_page;
  region_e         dec_region;

  bcs_phase u_phase (
    .clk(clk), .rst(rst), .phase(sys_clk),
    .state_end(state_end), .state_mid(state_mid)
  );

  bcs_page_reg #(.PG_W(PG_W)) u_page (
    .clk(clk), .rst(rst), .we(page_we), .din(page_din), .q(page_q)
  );

  bcs_decode #(
    .LA_W(LA_W), .PG_W(PG_W), .MEM_LO(MEM_LO), .MEM_HI(MEM_HI), .REG_LO(REG_LO)
  ) u_decode (
    .max_mode(max_mode), .page(page_q), .offset(req_addr),
    .page_eff(dec_page), .region(dec_region)
  );

  // access state, updated only at state boundaries
  logic              busy_q, half_q, wr_q, word_q, maxm_q;
  region_e           rgn_q;
  logic [1:0]        t_q;
  logic [LA_W-1:0]   off_q;
  logic [PG_W-1:0]   pg_q;
  logic [WORD_W-1:0] wdat_q;

  logic              n_busy, n_half, n_wr, n_word, n_maxm;
  region_e           n_rgn;
  logic [1:0]        n_t;
  logic [LA_W-1:0]   n_off;
  logic [PG_W-1:0]   n_pg;
  logic [WORD_W-1:0] n_wdat;

  logic [1:0] len;
  logic       split_q, final_t, last, can_take;

  assign len      = (rgn_q == RG_MEM) ? WIDE_STATES : NARROW_STATES;
  assign split_q  = word_q && (rgn_q != RG_MEM);
  assign final_t  = busy_q && (t_q == len);
  assign last     = final_t && (!split_q || half_q);
  assign can_take = !busy_q || last;

  always_comb begin
    n_busy = busy_q;
    n_half = half_q;
    n_wr   = wr_q;
    n_word = word_q;
    n_maxm = maxm_q;
    n_rgn  = rgn_q;
    n_t    = t_q;
    n_off  = off_q;
    n_pg   = pg_q;
    n_wdat = wdat_q;
    if (state_end) begin
      if (can_take) begin
        if (req_valid) begin
          n_busy = 1'b1;
          n_half = 1'b0;
          n_wr   = req_write;
          n_word = req_word;
          n_maxm = max_mode;
          n_rgn  = dec_region;
          n_t    = 2'd1;
          n_off  = req_addr;
          n_pg   = dec_page;
          n_wdat = req_wdata;
        end else begin
          n_busy = 1'b0;
        end
      end else if (final_t) begin
        // first byte of a split word finished: move to the next offset, same page
        n_half = 1'b1;
        n_t    = 2'd1;
        n_off  = off_q + 1'b1;
      end else begin
        n_t = t_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      wr_q   <= 1'b0;
      word_q <= 1'b0;
      maxm_q <= 1'b0;
      rgn_q  <= RG_NONE;
      t_q    <= 2'd0;
      off_q  <= '0;
      pg_q   <= '0;
      wdat_q <= '0;
    end else begin
      busy_q <= n_busy;
      half_q <= n_half;
      wr_q   <= n_wr;
      word_q <= n_word;
      maxm_q <= n_maxm;
      rgn_q  <= n_rgn;
      t_q    <= n_t;
      off_q  <= n_off;
      pg_q   <= n_pg;
      wdat_q <= n_wdat;
    end
  end

  // strobes registered from the next state so they switch on state boundaries
  logic [BYTE_W-1:0] n_byte;
  logic              n_ext_act;

  assign n_byte    = (n_word && !n_half) ? n_wdat[WORD_W-1:BYTE_W] : n_wdat[BYTE_W-1:0];
  assign n_ext_act = n_busy && (n_rgn == RG_EXT) && (n_t >= 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= 2'b00;
      mem_wdata <= '0;
      reg_en    <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      ext_addr  <= '0;
      ext_as_n  <= 1'b1;
      ext_rd_n  <= 1'b1;
      ext_wr_n  <= 1'b1;
      ext_wdata <= '0;
    end else if (state_end) begin
      mem_en    <= n_busy && (n_rgn == RG_MEM);
      mem_we    <= n_busy && (n_rgn == RG_MEM) && n_wr;
      mem_addr  <= n_off[LA_W-1:1];
      mem_be    <= n_word ? 2'b11 : (n_off[0] ? 2'b01 : 2'b10);
      mem_wdata <= n_word ? n_wdat : {2{n_wdat[BYTE_W-1:0]}};
      reg_en    <= n_busy && (n_rgn == RG_REG);
      reg_we    <= n_busy && (n_rgn == RG_REG) && n_wr;
      reg_addr  <= n_off[REG_AW-1:0];
      reg_wdata <= n_byte;
      if (n_busy && (n_rgn == RG_EXT))
        ext_addr <= {n_pg, n_off};
      ext_as_n  <= !n_ext_act;
      ext_rd_n  <= !(n_ext_act && !n_wr);
      ext_wr_n  <= !(n_ext_act && n_wr);
      ext_wdata <= n_byte;
    end
  end

  // handshake outputs registered at mid-state, valid for the second half
  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      req_ready <= 1'b0;
    end else begin
      done      <= state_mid && last;
      req_ready <= state_mid && can_take;
    end
  end

  bcs_rd_merge #(.BYTE_W(BYTE_W)) u_merge (
    .clk(clk), .rst(rst),
    .cap_en(state_mid && final_t && !wr_q),
    .region(rgn_q), .word(word_q), .half(half_q), .lane_odd(off_q[0]),
    .mem_rdata(mem_rdata), .reg_rdata(reg_rdata), .ext_rdata(ext_rdata),
    .rdata(rdata)
  );

  assert_ext_quiet_mem_R4: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (ext_as_n && ext_rd_n && ext_wr_n));

  assert_done_late_half_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> sys_clk);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_en, reg_en, ~ext_as_n}));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ext_as_n && !$past(ext_as_n)) |-> $stable(ext_addr));

  assert_min_page_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!ext_as_n && !maxm_q) |-> (ext_addr[PA_W-1:LA_W] == '0));
endmodule

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic max_mode = 1'b0;
  logic page_we = 1'b0;
  logic [3:0] page_din = 4'h0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_addr = 16'h0;
  logic req_write = 1'b0;
  logic req_word = 1'b0;
  logic [15:0] req_wdata = 16'h0;
  logic done;
  logic [15:0] rdata;
  logic sys_clk;
  logic mem_en, mem_we;
  logic [14:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0;
  logic reg_en, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [19:0] ext_addr;
  logic ext_as_n, ext_rd_n, ext_wr_n;
  logic [7:0] ext_wdata, ext_rdata;

  always #10 clk = ~clk;

  bus_cycle_seq dut (
    .clk(clk), .rst(rst), .max_mode(max_mode), .page_we(page_we), .page_din(page_din),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .sys_clk(sys_clk),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ext_addr(ext_addr), .ext_as_n(ext_as_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  function automatic logic [7:0] regf(input logic [6:0] x);
    return {x[3:0], x[6:3]} ^ 8'h96;
  endfunction
  function automatic logic [7:0] extf(input logic [19:0] p);
    return p[7:0] ^ {p[19:16], p[11:8]} ^ 8'h3C;
  endfunction

  assign reg_rdata = regf(reg_addr);
  assign ext_rdata = extf(ext_addr);

  logic [15:0] mem_arr [512];
  logic [15:0] exp_mem [512];
  initial for (int i = 0; i < 512; i++) mem_arr[i] = 16'(i * 16'h0101) ^ 16'hA5C3;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we && mem_be[1]) mem_arr[mem_addr[8:0]][15:8] <= mem_wdata[15:8];
      if (mem_we && mem_be[0]) mem_arr[mem_addr[8:0]][7:0]  <= mem_wdata[7:0];
      mem_rdata <= mem_arr[mem_addr[8:0]];
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  logic       cur_max = 1'b0;
  logic [3:0] cur_pg  = 4'h0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  int o_cyc, o_as, o_rd, o_wr, o_memext, o_rdybusy;
  logic [19:0] o_ea0, o_ea1;
  logic [7:0]  o_eb0, o_eb1, o_rb0, o_rb1;
  logic [6:0]  o_ra0, o_ra1;
  logic [15:0] o_rdata;
  logic o_rdy_done, o_phi_done;

  task automatic run(input logic [15:0] a, input logic wr, input logic wd, input logic [15:0] wdat,
                     input logic pgw, input logic [3:0] pgv);
    int k;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_word = wd; req_wdata = wdat;
    page_we = pgw; page_din = pgv;
    @(negedge clk);
    req_valid = 1'b0; page_we = 1'b0;
    o_as = 0; o_rd = 0; o_wr = 0; o_memext = 0; o_rdybusy = 0; o_cyc = 99;
    o_ea0 = '0; o_ea1 = '0; o_eb0 = '0; o_eb1 = '0; o_rb0 = '0; o_rb1 = '0;
    o_ra0 = '0; o_ra1 = '0; o_rdata = '0; o_rdy_done = 1'b0; o_phi_done = 1'b0;
    k = 1;
    while (k < 40) begin
      if (!ext_as_n) o_as++;
      if (!ext_rd_n) o_rd++;
      if (!ext_wr_n) o_wr++;
      if (mem_en && (!ext_as_n || !ext_rd_n || !ext_wr_n)) o_memext++;
      if (k == 1) begin o_ra0 = reg_addr; o_rb0 = reg_wdata; end
      if (k == 7) begin o_ra1 = reg_addr; o_rb1 = reg_wdata; end
      if (k == 3) begin o_ea0 = ext_addr; o_eb0 = ext_wdata; end
      if (k == 9) begin o_ea1 = ext_addr; o_eb1 = ext_wdata; end
      if (done) begin
        o_cyc = k; o_rdata = rdata; o_rdy_done = req_ready; o_phi_done = sys_clk;
        break;
      end
      if (req_ready) o_rdybusy++;
      k++;
      @(negedge clk);
    end
  endtask

  task automatic verify(input logic [15:0] a, input logic wr, input logic wd, input logic [15:0] wdat);
    logic [3:0]  pe;
    logic [15:0] a1;
    logic [15:0] er;
    int rg;
    pe = cur_max ? cur_pg : 4'h0;
    a1 = a + 16'd1;
    if (pe == 4'h0 && a >= 16'hFF80)      rg = 2;
    else if (pe == 4'h0 && a >= 16'hFB80) rg = 1;
    else                                  rg = 3;
    chk("R1", "sys_clk at done", 32'(o_phi_done), 32'd1);
    chk("R8", "ready with done", 32'(o_rdy_done), 32'd1);
    chk("R8", "ready while busy", 32'(o_rdybusy), 32'd0);
    if (rg == 1) begin
      chk("R2", "mem cycles", 32'(o_cyc), 32'd4);
      chk("R4", "ext strobe in mem", 32'(o_memext + o_as + o_rd + o_wr), 32'd0);
      if (wr) begin
        if (wd) exp_mem[a[9:1]] = wdat;
        else if (a[0]) exp_mem[a[9:1]][7:0] = wdat[7:0];
        else exp_mem[a[9:1]][15:8] = wdat[7:0];
      end else begin
        er = wd ? exp_mem[a[9:1]] : {8'h00, a[0] ? exp_mem[a[9:1]][7:0] : exp_mem[a[9:1]][15:8]};
        chk("R2", "mem rdata", 32'(o_rdata), 32'(er));
      end
    end else if (rg == 2) begin
      chk("R3", "reg cycles", 32'(o_cyc), wd ? 32'd12 : 32'd6);
      chk("R3", "ext idle in reg", 32'(o_as), 32'd0);
      if (wr) begin
        chk("R3", "reg addr first", 32'(o_ra0), 32'(a[6:0]));
        chk("R11", "reg first byte", 32'(o_rb0), 32'(wd ? wdat[15:8] : wdat[7:0]));
        if (wd) begin
          chk("R6", "reg addr second", 32'(o_ra1), 32'(a1[6:0]));
          chk("R11", "reg second byte", 32'(o_rb1), 32'(wdat[7:0]));
        end
      end else begin
        er = wd ? {regf(a[6:0]), regf(a1[6:0])} : {8'h00, regf(a[6:0])};
        chk("R12", "reg rdata", 32'(o_rdata), 32'(er));
      end
    end else begin
      chk("R9", "ext cycles", 32'(o_cyc), wd ? 32'd12 : 32'd6);
      chk("R9", "as low cycles", 32'(o_as), wd ? 32'd8 : 32'd4);
      chk("R9", "wr low cycles", 32'(o_wr), wr ? 32'(o_as) : 32'd0);
      chk("R9", "rd low cycles", 32'(o_rd), wr ? 32'd0 : 32'(o_as));
      chk(cur_max ? "R5" : "R7", "ext addr first", 32'(o_ea0), 32'({pe, a}));
      if (wd) chk("R6", "ext addr second", 32'(o_ea1), 32'({pe, a1}));
      if (wr) begin
        chk("R11", "ext first byte", 32'(o_eb0), 32'(wd ? wdat[15:8] : wdat[7:0]));
        if (wd) chk("R11", "ext second byte", 32'(o_eb1), 32'(wdat[7:0]));
      end else begin
        er = wd ? {extf({pe, a}), extf({pe, a1})} : {8'h00, extf({pe, a})};
        chk("R12", "ext rdata", 32'(o_rdata), 32'(er));
      end
    end
  endtask

  task automatic op(input logic [15:0] a, input logic wr, input logic wd, input logic [15:0] wdat);
    run(a, wr, wd, wdat, 1'b0, 4'h0);
    verify(a, wr, wd, wdat);
  endtask

  task automatic set_page(input logic [3:0] v);
    @(negedge clk);
    page_we = 1'b1; page_din = v;
    @(negedge clk);
    page_we = 1'b0;
    cur_pg = v;
  endtask

  task automatic sweep(input logic [15:0] a);
    for (int wr = 1; wr >= 0; wr--)
      for (int wd = 1; wd >= 0; wd--)
        op(a, wr[0], wd[0], (a ^ 16'h5AA5) + 16'(wd * 3));
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [15:0] sweep_addrs [15];
  initial begin
    sweep_addrs = '{16'hFB80, 16'hFB81, 16'hFC33, 16'hFF7E, 16'hFF7F,
                    16'hFF80, 16'hFF81, 16'hFFC4, 16'hFFFE, 16'hFFFF,
                    16'h0000, 16'h1235, 16'h7FFF, 16'hFB7F, 16'h8001};
    for (int i = 0; i < 512; i++) exp_mem[i] = 16'(i * 16'h0101) ^ 16'hA5C3;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "ready in reset", 32'(req_ready), 32'd0);
    chk("R13", "done in reset", 32'(done), 32'd0);
    chk("R13", "enables in reset", 32'({mem_en, reg_en}), 32'd0);
    chk("R13", "ext strobes in reset", 32'({ext_as_n, ext_rd_n, ext_wr_n}), 32'h7);
    chk("R13", "rdata in reset", 32'(rdata), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R7: minimum mode with a nonzero page register that must be ignored
    set_page(4'h5);
    for (int i = 0; i < 15; i++) sweep(sweep_addrs[i]);

    // R5/R6: maximum mode across pages
    max_mode = 1'b1; cur_max = 1'b1;
    set_page(4'h0);
    sweep(16'hFF90); sweep(16'hFC00); sweep(16'h4000);
    set_page(4'h3);
    sweep(16'hFFFF); sweep(16'hFF80); sweep(16'hFC00);
    set_page(4'hF);
    sweep(16'h0001); sweep(16'hFFFF);

    // R10: page write at the accepting edge applies only to the following access
    run(16'h2222, 1'b0, 1'b0, 16'h0, 1'b1, 4'h9);
    verify(16'h2222, 1'b0, 1'b0, 16'h0);
    cur_pg = 4'h9;
    op(16'h2222, 1'b0, 1'b0, 16'h0);
    chk("R10", "new page used", 32'(o_ea0[19:16]), 32'h9);

    // R8: done is a single-cycle pulse when no new request follows
    @(negedge clk);
    chk("R8", "done dropped", 32'(done), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule